// File: doc/BRIEF.md
# Dual-Slope Soft Mute Ramp

This block fades a signed audio sample stream down to a deep-mute level and back up to unity. It does this with a gain coefficient that moves in equal linear steps instead of switching abruptly. Two sources can request the fade, and either one is enough. The first is a mute bit written by the control bus. The second is an external mute pin that is active low, so a pulled-up, undriven pin asks for nothing. The pin is brought into the clock domain through a two-flop synchronizer.

A slope-select bit chooses between a fast ramp and a slow ramp. By default the fast ramp lasts about 1 ms and the slow ramp about 35 ms at a 100 MHz clock. Both lengths are parameters given in clock cycles. The slope-select bit may change partway through a ramp. The new rate then applies from the next step, and the gain does not jump.

Each valid input sample is multiplied by the current gain and scaled back to the sample width with saturation. The result appears one cycle later together with a valid strobe. The current gain is also visible on a port. A status flag reports that soft mute is active.

Top module: `soft_mute_ramp`

## Requirements
- R1: After reset, `gain_o` is unity (2^(GAIN_W-1), 32768 for GAIN_W=16), `out_valid_o` is 0, `out_sample_o` is 0 and `active_o` is 0.
- R2: A mute request moves the gain down by STEP on each step tick, so k ticks after the request the gain is unity minus k*STEP. Ticks come every DIV cycles, where DIV = max(1, ramp_cycles / ceil((unity - FLOOR_GAIN)/STEP)), and the first tick falls DIV cycles after the request is first seen. The gain is never taken below FLOOR_GAIN, so the last step may be shorter than STEP.
- R3: `mute_pin_n_i` low requests mute after a two-cycle synchronizer. With the pin high and `mute_bit_i` low, the gain stays at unity.
- R4: `slow_sel_i`=0 selects the fast ramp length FAST_RAMP_CYC. `slow_sel_i`=1 selects the slow ramp length SLOW_RAMP_CYC.
- R5: While either source requests mute, the gain reaches FLOOR_GAIN and then holds there. The default value of 33/32768 is about 60 dB below unity.
- R6: Once both sources release, the gain climbs by STEP per tick at the selected rate until it reaches unity and never exceeds it.
- R7: When `slow_sel_i` changes during a ramp, the new tick spacing applies from the next step, and the gain changes by at most STEP per clock.
- R8: When `in_valid_i` is high, the next cycle shows `out_valid_o`=1 and `out_sample_o` = sat(in_sample × gain >>> (GAIN_W-1)), using the gain present at that edge. At unity gain the output equals the input, including full scale. With no valid input, `out_valid_o` is 0 and `out_sample_o` holds its value.
- R9: `active_o` is 1 while either source requests mute or the gain is below unity. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample strobe |
| in_sample_i | input | SAMPLE_W | Signed input sample |
| mute_bit_i | input | 1 | Soft mute request from the register, active high |
| slow_sel_i | input | 1 | Ramp slope: 0 fast, 1 slow |
| mute_pin_n_i | input | 1 | External soft mute request, active low, asynchronous |
| out_valid_o | output | 1 | Output sample strobe |
| out_sample_o | output | SAMPLE_W | Signed scaled sample |
| gain_o | output | GAIN_W | Current gain, unity = 2^(GAIN_W-1) |
| active_o | output | 1 | Soft mute active status |

## Verification
The case hardest to reach from the ports is a slope change that lands in the middle of a ramp. It must take effect on the following step without disturbing the gain already reached. The stimulus starts a slow descent and switches to the fast slope exactly at a step boundary. It then checks that the floor is reached after the remaining steps at the fast spacing.

A second difficult case is a mute held by two overlapping sources, where releasing only one of them must leave the gain at the floor. The bench reaches it by asserting the register bit while the pin is still low and then releasing the pin. Random samples are also sent during a slow ramp so that scaling is checked at many intermediate gains.

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int SAMPLE_W      = 16,
  parameter int GAIN_W        = 16,
  parameter int FLOOR_GAIN    = 33,
  parameter int STEP          = 64,
  parameter int FAST_RAMP_CYC = 100000,
  parameter int SLOW_RAMP_CYC = 3500000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid_i,
  input  logic signed [SAMPLE_W-1:0] in_sample_i,
  input  logic                       mute_bit_i,
  input  logic                       slow_sel_i,
  input  logic                       mute_pin_n_i,
  output logic                       out_valid_o,
  output logic signed [SAMPLE_W-1:0] out_sample_o,
  output logic [GAIN_W-1:0]          gain_o,
  output logic                       active_o
);

  localparam int UNITY    = 1 << (GAIN_W - 1);
  localparam int SPAN     = UNITY - FLOOR_GAIN;
  localparam int NTICKS   = (SPAN + STEP - 1) / STEP;
  localparam int FAST_DIV = (FAST_RAMP_CYC / NTICKS > 0) ? FAST_RAMP_CYC / NTICKS : 1;
  localparam int SLOW_DIV = (SLOW_RAMP_CYC / NTICKS > 0) ? SLOW_RAMP_CYC / NTICKS : 1;
  localparam int MAX_DIV  = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CNT_W    = $clog2(MAX_DIV + 1);
  localparam int PW       = SAMPLE_W + GAIN_W + 1;

  localparam logic [GAIN_W-1:0] UNITY_G = GAIN_W'(UNITY);
  localparam logic [GAIN_W-1:0] FLOOR_G = GAIN_W'(FLOOR_GAIN);
  localparam logic [GAIN_W-1:0] STEP_G  = GAIN_W'(STEP);
  localparam logic signed [PW-1:0] SAT_HI = PW'((longint'(1) << (SAMPLE_W - 1)) - 1);
  localparam logic signed [PW-1:0] SAT_LO = -SAT_HI - 1;

  logic [1:0]        pin_sync;
  logic              req;
  logic [GAIN_W-1:0] gain_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  div_m1;
  logic              moving, tick;
  logic [GAIN_W-1:0] room_dn, room_up;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_sync <= 2'b11;
    else        pin_sync <= {pin_sync[0], mute_pin_n_i};

  assign req     = mute_bit_i | ~pin_sync[1];
  assign moving  = req ? (gain_q != FLOOR_G) : (gain_q != UNITY_G);
  assign div_m1  = slow_sel_i ? CNT_W'(SLOW_DIV - 1) : CNT_W'(FAST_DIV - 1);
  assign tick    = moving && (cnt_q >= div_m1);
  assign room_dn = gain_q - FLOOR_G;
  assign room_up = UNITY_G - gain_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               cnt_q <= '0;
    else if (!moving || tick) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gain_q <= UNITY_G;
    else if (tick) begin
      if (req) gain_q <= (room_dn > STEP_G) ? gain_q - STEP_G : FLOOR_G;
      else     gain_q <= (room_up > STEP_G) ? gain_q + STEP_G : UNITY_G;
    end

  logic signed [PW-1:0] prod, shifted;
  logic signed [SAMPLE_W-1:0] sat;

  assign prod    = in_sample_i * $signed({1'b0, gain_q});
  assign shifted = prod >>> (GAIN_W - 1);
  assign sat     = (shifted > SAT_HI) ? SAT_HI[SAMPLE_W-1:0] :
                   (shifted < SAT_LO) ? SAT_LO[SAMPLE_W-1:0] : shifted[SAMPLE_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid_o  <= 1'b0;
      out_sample_o <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_sample_o <= sat;
    end

  assign gain_o   = gain_q;
  assign active_o = req | (gain_q != UNITY_G);

  function automatic logic [SAMPLE_W:0] mag(input logic signed [SAMPLE_W-1:0] v);
    logic signed [SAMPLE_W:0] e;
    e = {v[SAMPLE_W-1], v};
    return (e < 0) ? -e : e;
  endfunction

  assert_gain_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q >= FLOOR_G) && (gain_q <= UNITY_G));

  assert_step_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q >= $past(gain_q)) ? ((gain_q - $past(gain_q)) <= STEP_G)
                              : (($past(gain_q) - gain_q) <= STEP_G));

  assert_floor_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && gain_q == FLOOR_G) |=> (gain_q == FLOOR_G));

  assert_release_no_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req) |=> (gain_q >= $past(gain_q)));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid_i) |=> $stable(out_sample_o));

  assert_out_mag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> (mag(out_sample_o) <= mag($past(in_sample_i))));

endmodule

// File: tb/soft_mute_ramp_tb.sv
module soft_mute_ramp_tb;
  localparam int SW = 16, GW = 16, FL = 33, ST = 1024, FR = 128, SR = 640;
  localparam int UN = 1 << (GW - 1);
  localparam int NT = (UN - FL + ST - 1) / ST;
  localparam int FD = FR / NT;
  localparam int SD = SR / NT;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, mute_bit = 0, slow_sel = 0, pin_n = 1;
  logic signed [SW-1:0] in_sample = '0;
  logic out_valid, active;
  logic signed [SW-1:0] out_sample;
  logic [GW-1:0] gain;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  soft_mute_ramp #(.SAMPLE_W(SW), .GAIN_W(GW), .FLOOR_GAIN(FL), .STEP(ST),
                   .FAST_RAMP_CYC(FR), .SLOW_RAMP_CYC(SR)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_sample_i(in_sample),
    .mute_bit_i(mute_bit), .slow_sel_i(slow_sel), .mute_pin_n_i(pin_n),
    .out_valid_o(out_valid), .out_sample_o(out_sample), .gain_o(gain), .active_o(active));

  function automatic int scale(int x, int g);
    longint p;
    p = (longint'(x) * longint'(g)) >>> (GW - 1);
    if (p > UN - 1) p = UN - 1;
    if (p < -UN) p = -UN;
    return int'(p);
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int x);
    int g;
    g = int'(gain);
    in_valid = 1; in_sample = SW'(x);
    @(negedge clk);
    in_valid = 0;
    chk("R8 valid", int'(out_valid), 1);
    chk("R8 sample", int'(out_sample), scale(x, g));
  endtask

  initial begin
    int held;
    void'($urandom(32'd4242));
    wait_n(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 gain", int'(gain), UN);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 sample", int'(out_sample), 0);
    chk("R1 active", int'(active), 0);

    send(-UN); chk("R8 full-scale neg", int'(out_sample), -UN);
    send(UN - 1); chk("R8 full-scale pos", int'(out_sample), UN - 1);
    for (int i = 0; i < 20; i++) begin
      int x;
      x = int'($urandom_range(65535)) - 32768;
      send(x);
      chk("R8 unity passthrough", int'(out_sample), x);
    end
    held = int'(out_sample);
    wait_n(3);
    chk("R8 hold value", int'(out_sample), held);
    chk("R8 no valid", int'(out_valid), 0);
    wait_n(20);
    chk("R3 pin high no mute", int'(gain), UN);
    chk("R3 idle inactive", int'(active), 0);

    mute_bit = 1;
    wait_n(5 * FD);
    chk("R2 linear step", int'(gain), UN - 5 * ST);
    chk("R9 active ramp", int'(active), 1);
    wait_n(NT * FD - 5 * FD - 1);
    chk("R2 one step before floor", int'(gain), UN - (NT - 1) * ST);
    wait_n(1);
    chk("R5 floor reached", int'(gain), FL);
    wait_n(50);
    chk("R5 floor held", int'(gain), FL);
    for (int i = 0; i < 10; i++) send(int'($urandom_range(65535)) - 32768);

    mute_bit = 0;
    wait_n(3 * FD);
    chk("R6 ramp up", int'(gain), FL + 3 * ST);
    chk("R9 active rising", int'(active), 1);
    wait_n(NT * FD - 3 * FD);
    chk("R6 unity reached", int'(gain), UN);
    chk("R9 inactive", int'(active), 0);

    slow_sel = 1; pin_n = 0;
    wait_n(2 + NT * SD - 1);
    chk("R4 slow one before floor", int'(gain), UN - (NT - 1) * ST);
    wait_n(1);
    chk("R3 pin floor", int'(gain), FL);

    mute_bit = 1; pin_n = 1;
    wait_n(100);
    chk("R5 one source holds", int'(gain), FL);
    chk("R9 active held", int'(active), 1);
    slow_sel = 0; mute_bit = 0;
    wait_n(NT * FD);
    chk("R6 both released", int'(gain), UN);

    slow_sel = 1; mute_bit = 1;
    wait_n(10 * SD);
    chk("R7 slow part", int'(gain), UN - 10 * ST);
    slow_sel = 0;
    wait_n(22 * FD - 1);
    chk("R7 fast part", int'(gain), UN - (NT - 1) * ST);
    wait_n(1);
    chk("R7 floor after switch", int'(gain), FL);

    slow_sel = 1; mute_bit = 0;
    for (int i = 0; i < 100; i++) begin
      wait_n(int'($urandom_range(5)));
      send(int'($urandom_range(65535)) - 32768);
    end
    wait_n(NT * SD);
    chk("R6 slow unity", int'(gain), UN);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule